// File: doc/BRIEF.md
# XOR Phase/Frequency Discriminator

This block is the error detector of a digital phase-locked loop. It takes a reference pulse train and an oscillator pulse train, both asynchronous to the system clock. It produces a complementary pair of single-bit error outputs, and the mean duty cycle of that pair carries the phase error. Each input is synchronized and turned into a rising-edge strobe. Each strobe then toggles its own half-rate flop. The phase comparison is the XOR of the two half-rate signals. This gives a constant gain straight through the lock point, which sits where the two half-rate signals are 180 degrees apart, so there is no dead zone.

The inputs can drift far apart in frequency. A second path watches the order in which edges arrive on the two sides. If one side shows two rising edges with none from the other side in between, that side's flag is set and the error level is pinned in the direction that steers the oscillator back. The flag releases once the edges have alternated for one full pair. After that, the XOR path drives the output again. A status output shows whether an override is in force.

Top module: `pfd_xor_disc`

## Requirements
- R1: While rst_ni is low, and directly after it is released, both half-rate flops are 0 and no flag is active, so err_o=0, err_no=1 and override_o=0. After reset, the first rising edge on either side does not set a flag.
- R2: Each sampled rising edge of an input toggles that side's half-rate flop. With no flag active, err_o equals the XOR of the reference half-rate flop and the oscillator half-rate flop.
- R3: err_no is the exact complement of err_o in every cycle.
- R4: Two reference rising edges with no oscillator rising edge between them set the slow flag. While the slow flag is active, err_o is forced to 1.
- R5: Two oscillator rising edges with no reference rising edge between them set the fast flag. While the fast flag is active, err_o is forced to 0.
- R6: An active flag clears once one reference edge and one oscillator edge have followed it, in either order, with no double edge on the same side. The XOR result then drives err_o again.
- R7: Rising edges on both inputs in the same system clock cycle count as an alternating pair. Such an event never sets a flag, and it clears any active flag.
- R8: override_o is 1 exactly when the slow or fast flag was active in the previous cycle. The two flags are never active together.
- R9: A rising input level that is set up before clock edge k shows its effect on err_o after edge k+4 and not earlier. The path is two synchronizer flops, an edge register, the half-rate flop and the output register. Each input must stay high and low for at least two clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; must run at least four times faster than either input toggles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse train, asynchronous |
| osc_i | input | 1 | Oscillator (feedback) pulse train, asynchronous |
| err_o | output | 1 | Noninverted phase/frequency error level |
| err_no | output | 1 | Inverted phase/frequency error level |
| override_o | output | 1 | High while a frequency flag forces the error level |

## Verification
The clash that matters is between the two edge strobes. A reference edge and an oscillator edge can land in the same system clock cycle, and then the double-edge detector and the alternation counter both act on that cycle. The bench provokes this by driving both inputs high on the same clock, in two cases: while a fast override is active, and right after a lone oscillator edge. In both cases it checks that no flag is set, that any active flag clears, and that both half-rate flops toggled. A bound property also checks that a coincident strobe is never followed by an active flag.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_REF  = 2'd1,
    SIDE_OSC  = 2'd2
  } side_e;

  // edges of alternation needed to release a flag: one per side
  localparam int unsigned PAIR_EDGES = 2;
  localparam int unsigned ALT_W      = $clog2(PAIR_EDGES + 1);
  localparam int unsigned N_CH       = 2;
  localparam int unsigned CH_REF     = 0;
  localparam int unsigned CH_OSC     = 1;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
      rise_q <= sync_q[STAGES-1] & ~prev_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/pfd_div2.sv
module pfd_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic half_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_q <= 1'b0;
    else if (step_i) half_q <= ~half_q;
  end

  assign half_o = half_q;
endmodule

// File: rtl/pfd_freq_flags.sv
module pfd_freq_flags
  import pfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic osc_rise_i,
  output logic slow_o,
  output logic fast_o
);
  side_e            last_q, last_d;
  logic [ALT_W-1:0] alt_q, alt_d;
  logic             slow_q, slow_d;
  logic             fast_q, fast_d;

  always_comb begin
    last_d = last_q;
    alt_d  = alt_q;
    slow_d = slow_q;
    fast_d = fast_q;
    if (ref_rise_i && osc_rise_i) begin
      // coincident edges form a whole pair
      last_d = SIDE_NONE;
      alt_d  = ALT_W'(PAIR_EDGES);
    end else if (ref_rise_i) begin
      if (last_q == SIDE_REF) begin
        slow_d = 1'b1;
        fast_d = 1'b0;
        alt_d  = '0;
      end else if (alt_q != ALT_W'(PAIR_EDGES)) begin
        alt_d  = alt_q + 1'b1;
      end
      last_d = SIDE_REF;
    end else if (osc_rise_i) begin
      if (last_q == SIDE_OSC) begin
        fast_d = 1'b1;
        slow_d = 1'b0;
        alt_d  = '0;
      end else if (alt_q != ALT_W'(PAIR_EDGES)) begin
        alt_d  = alt_q + 1'b1;
      end
      last_d = SIDE_OSC;
    end
    if (alt_d == ALT_W'(PAIR_EDGES)) begin
      slow_d = 1'b0;
      fast_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= SIDE_NONE;
      alt_q  <= ALT_W'(PAIR_EDGES);
      slow_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      last_q <= last_d;
      alt_q  <= alt_d;
      slow_q <= slow_d;
      fast_q <= fast_d;
    end
  end

  assign slow_o = slow_q;
  assign fast_o = fast_q;
endmodule

// File: rtl/pfd_xor_disc.sv
module pfd_xor_disc
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic osc_i,
  output logic err_o,
  output logic err_no,
  output logic override_o
);
  logic [N_CH-1:0] in_vec;
  logic [N_CH-1:0] rise;
  logic [N_CH-1:0] half;

  logic ref_rise, osc_rise;
  logic ref_half, osc_half;
  logic slow_flag, fast_flag;
  logic phase_x;
  logic err_q, errn_q, ovr_q;

  assign in_vec[CH_REF] = ref_i;
  assign in_vec[CH_OSC] = osc_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (in_vec[g]),
      .rise_o (rise[g])
    );
    pfd_div2 u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (rise[g]),
      .half_o (half[g])
    );
  end

  assign ref_rise = rise[CH_REF];
  assign osc_rise = rise[CH_OSC];
  assign ref_half = half[CH_REF];
  assign osc_half = half[CH_OSC];

  pfd_freq_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (ref_rise),
    .osc_rise_i (osc_rise),
    .slow_o     (slow_flag),
    .fast_o     (fast_flag)
  );

  assign phase_x = ref_half ^ osc_half;

  // both polarities registered separately so neither is a gate delay behind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      errn_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else begin
      err_q  <= slow_flag ? 1'b1 : (fast_flag ? 1'b0 : phase_x);
      errn_q <= slow_flag ? 1'b0 : (fast_flag ? 1'b1 : ~phase_x);
      ovr_q  <= slow_flag | fast_flag;
    end
  end

  assign err_o      = err_q;
  assign err_no     = errn_q;
  assign override_o = ovr_q;
endmodule

// File: rtl/pfd_xor_disc_chk.sv
module pfd_xor_disc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_rise,
  input logic osc_rise,
  input logic ref_half,
  input logic osc_half,
  input logic slow_flag,
  input logic fast_flag,
  input logic err_o,
  input logic err_no,
  input logic override_o
);
  AST_OUT_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o != err_no); // R3

  AST_REF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rise |=> ref_half != $past(ref_half)); // R2

  AST_OSC_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_rise |=> osc_half != $past(osc_half)); // R2

  AST_SLOW_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_flag |=> err_o); // R4

  AST_FAST_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_flag |=> !err_o); // R5

  AST_BOTH_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_rise && osc_rise) |=> !(slow_flag || fast_flag)); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slow_flag && fast_flag)); // R8

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_flag || fast_flag) |=> override_o); // R8

  AST_OVR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slow_flag || fast_flag) |=> !override_o); // R8
endmodule

bind pfd_xor_disc pfd_xor_disc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_rise   (ref_rise),
  .osc_rise   (osc_rise),
  .ref_half   (ref_half),
  .osc_half   (osc_half),
  .slow_flag  (slow_flag),
  .fast_flag  (fast_flag),
  .err_o      (err_o),
  .err_no     (err_no),
  .override_o (override_o)
);

// File: tb/pfd_xor_disc_bench.sv
module pfd_xor_disc_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0;
  logic osc_i = 1'b0;
  logic err_o, err_no, override_o;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  pfd_xor_disc u_pfd_xor_disc (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .osc_i      (osc_i),
    .err_o      (err_o),
    .err_no     (err_no),
    .override_o (override_o)
  );

  // {pulse ref, pulse osc, expected err_o, expected override_o}
  localparam int NV = 16;
  localparam logic [3:0] VEC [NV] = '{
    4'b1010, 4'b0100, 4'b1010, 4'b1011, // R2 xor, then double ref (R4)
    4'b1011, 4'b0111, 4'b1010, 4'b0100, // R6 release after osc,ref
    4'b0101, 4'b1110, 4'b0100, 4'b1100, // R5 double osc, R7 coincident
    4'b0110, 4'b0101, 4'b1001, 4'b0100  // R5 again, R6 release ref,osc
  };
  string tag [NV] = '{"R2", "R2", "R2", "R4", "R4", "R6", "R6", "R2",
                      "R5", "R7", "R2", "R7", "R2", "R5", "R6", "R6"};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic r, input logic o);
    @(negedge clk);
    ref_i = r;
    osc_i = o;
    repeat (4) @(negedge clk);
    ref_i = 1'b0;
    osc_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 err", err_o, 1'b0);
    check("R1 errn", err_no, 1'b1);
    check("R1 ovr", override_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 err idle", err_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][3], VEC[i][2]);
      check({tag[i], " err"}, err_o, VEC[i][1]);
      check("R3 errn", err_no, ~VEC[i][1]);
      check("R8 ovr", override_o, VEC[i][0]);
    end

    // R9 latency: ref half goes 0->1, err_o 0->1 after fourth edge
    @(negedge clk);
    ref_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 early", err_o, 1'b0);
    @(negedge clk);
    check("R9 on time", err_o, 1'b1);
    ref_i = 1'b0;
    repeat (6) @(negedge clk);

    // force fast flag, then reset in the middle of it
    pulse(1'b0, 1'b1);
    check("R2 osc", err_o, 1'b0);
    pulse(1'b0, 1'b1);
    check("R5 forced", err_o, 1'b0);
    check("R8 ovr set", override_o, 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 mid err", err_o, 1'b0);
    check("R1 mid errn", err_no, 1'b1);
    check("R1 mid ovr", override_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // first osc edge after reset: toggles half, sets no flag
    pulse(1'b0, 1'b1);
    check("R1 first edge err", err_o, 1'b1);
    check("R1 first edge ovr", override_o, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule